// File: doc/BRIEF.md
# Synchronous Burst Flash Read Interface

This block is the memory-side read port of a 32-bit flash device. A host drives a chip enable, an address-latch strobe, an output enable, a write enable and a burst-advance strobe. The block returns one double-word per beat, together with a ready strobe. A 16-bit read-configuration register chooses between a plain fixed-latency read and a clocked burst read. In burst mode, the same register sets the first-beat delay, the spacing between beats, the burst size, the wrap and ordering rules, the clock edge on which data is launched, and when ready is raised.

The array behind the port is a synchronous-read model with computed contents. This lets the host check every word it gets back. The configuration register is loaded by a write cycle that carries a command code in the upper half of the data bus. Any code outside the legal set is refused as a whole.

Top module: `bflash_rd_if`

## Requirements
- R1: After reset, ready is low, the output word is zero and asynchronous mode is selected. In asynchronous mode, a latch (ce_ni=0, lat_ni=0, we_ni=1 at a rising edge, edge 0) returns exactly one word after edge 2, with one cycle of ready and no address advance. The word at address a is (a * 0x00010001) ^ 0x5A5A0F0F, with a zero-extended to 32 bits.
- R2: A rising edge with ce_ni=0, we_ni=0 and din_i[31:16]=0x6000 loads din_i[15:0] into the configuration. The write is ignored if the latency code in bits 13..11 is 000, 110 or 111, if any of bits 14, 10, 5 or 4 is set, or if the command differs.
- R3: With bit 15 clear (burst mode), latency code c in 1..5 gives a first-beat delay of c+3 clocks. The first word appears after edge c+2, counting the latch edge as edge 0.
- R4: Bit 9 clear places beats on consecutive clocks. Bit 9 set places them two clocks apart.
- R5: Bits 2..0 give the burst size: 001 is 4 words, 010 is 8 words, and any other code is continuous linear reading. A fixed burst stops after its last word.
- R6: With bit 7 set (sequential), bit 3 clear wraps the address inside the aligned block of the burst size. Bit 3 set counts linearly past the block boundary.
- R7: With bit 7 clear, a fixed burst is interleaved: the low address bits are the latched ones XOR the beat position.
- R8: At each beat after the first, adv_ni low moves to the next position. adv_ni high repeats the previous word.
- R9: Bit 6 set launches data and ready on the falling clock edge, half a cycle after the rising-edge timing.
- R10: Bit 8 set raises ready in the cycle before each word appears, not in the cycle of the word.
- R11: dout_o carries data only while ce_ni=0, oe_ni=0 and we_ni=1, and is zero otherwise. Ready is not affected by this gating.
- R12: Raising ce_ni ends a burst. No ready or word follows until a new latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| lat_ni | input | 1 | Address latch strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| addr_i | input | AW | Double-word address |
| din_i | input | 32 | Command code and configuration value |
| dout_o | output | 32 | Read data |
| dout_en_o | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Data ready strobe |

## Verification
The hardest state to reach is a fixed burst interrupted by held beats. The bench must raise the advance strobe exactly on the clock where a beat fires, and then check that the word repeats and that the burst still ends at the block boundary. The driver therefore computes the fire edges from the programmed latency and spacing, and drives adv_ni only on those edges. The scoreboard holds both the expected word and the expected clock of each beat. Falling-edge launch and early ready are each caught by sampling the ready strobe before the falling edge, and by pairing each early strobe with the word in the following cycle.

// File: rtl/bfl_pkg.sv
`timescale 1ns/1ps
package bfl_pkg;
  localparam int DW = 32;
  localparam logic [15:0] CFG_CMD = 16'h6000;

  typedef struct packed {
    logic       async_m;
    logic [2:0] lat;
    logic       sp2;
    logic       early;
    logic       seq_o;
    logic       fall;
    logic       nowrap;
    logic [2:0] len;
  } cfg_t;

  localparam cfg_t CFG_RST = '{async_m: 1'b1, lat: 3'b011, sp2: 1'b0, early: 1'b0,
                               seq_o: 1'b1, fall: 1'b0, nowrap: 1'b0, len: 3'b001};

  function automatic cfg_t unpack_cfg(input logic [15:0] r);
    cfg_t c;
    c.async_m = r[15];
    c.lat     = r[13:11];
    c.sp2     = r[9];
    c.early   = r[8];
    c.seq_o   = r[7];
    c.fall    = r[6];
    c.nowrap  = r[3];
    c.len     = r[2:0];
    return c;
  endfunction

  function automatic logic cfg_legal(input logic [15:0] r);
    return (r[13:11] >= 3'd1) && (r[13:11] <= 3'd5) && !r[14] && !r[10] && (r[5:4] == 2'b00);
  endfunction

  function automatic logic [DW-1:0] array_word(input logic [DW-1:0] a);
    return (a * 32'h0001_0001) ^ 32'h5A5A_0F0F;
  endfunction
endpackage

// File: rtl/bfl_cfg_reg.sv
`timescale 1ns/1ps
module bfl_cfg_reg
  import bfl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output cfg_t        cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else if (wr_i && cfg_legal(wdata_i)) cfg_q <= unpack_cfg(wdata_i);
  end

  assign cfg_o = cfg_q;

  // R2: refused writes keep the register
  a_r2_reserved_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !cfg_legal(wdata_i) |=> $stable(cfg_q));
endmodule

// File: rtl/bfl_burst_seq.sv
`timescale 1ns/1ps
module bfl_burst_seq #(
  parameter int AW        = 8,
  parameter int ASYNC_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          async_i,
  input  logic [2:0]    lat_i,
  input  logic          sp2_i,
  input  logic          seq_i,
  input  logic          nowrap_i,
  input  logic [2:0]    len_i,
  input  logic          ce_ni,
  input  logic          lat_ni,
  input  logic          we_ni,
  input  logic          adv_ni,
  input  logic [AW-1:0] addr_i,
  output logic          fire_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam int TW = 4;

  logic          act_q, first_q;
  logic [TW-1:0] tmr_q;
  logic [AW-1:0] base_q, idx_q, idx_use, mask, n_m1;
  logic          latch, sel, fixed, last, step;

  always_comb begin
    latch   = !ce_ni && !lat_ni && we_ni;
    sel     = !ce_ni && we_ni && lat_ni;
    fire_o  = act_q && sel && (tmr_q == TW'(1));
    step    = fire_o && !first_q && !adv_ni && !async_i;
    idx_use = step ? idx_q + AW'(1) : idx_q;
    fixed   = !async_i && (len_i == 3'b001 || len_i == 3'b010);
    n_m1    = (len_i == 3'b010) ? AW'(7) : AW'(3);
    mask    = fixed ? n_m1 : '0;
    if (fixed && !seq_i)
      rd_addr_o = (base_q & ~mask) | ((base_q ^ idx_use) & mask);
    else if (fixed && !nowrap_i)
      rd_addr_o = (base_q & ~mask) | ((base_q + idx_use) & mask);
    else
      rd_addr_o = base_q + idx_use;
    last = async_i || (fixed && idx_use == n_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      first_q <= 1'b0;
      tmr_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
    end else if (latch) begin
      base_q  <= addr_i;
      act_q   <= 1'b1;
      first_q <= 1'b1;
      idx_q   <= '0;
      tmr_q   <= async_i ? TW'(ASYNC_LAT - 1) : TW'({1'b0, lat_i}) + TW'(2);
    end else if (!sel) begin
      act_q <= 1'b0;
    end else if (fire_o) begin
      idx_q   <= idx_use;
      first_q <= 1'b0;
      tmr_q   <= sp2_i ? TW'(2) : TW'(1);
      if (last) act_q <= 1'b0;
    end else if (act_q) begin
      tmr_q <= tmr_q - TW'(1);
    end
  end

  a_r1_async_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && async_i |=> !act_q);
  a_r8_hold_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !first_q && adv_ni |=> $stable(idx_q));
  a_r5_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && fixed |-> idx_q <= n_m1);
  a_r12_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !act_q);
  a_r3_tmr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (tmr_q != '0) && (tmr_q <= TW'(7)));
  a_r4_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && sp2_i && !async_i |=> !fire_o);
endmodule

// File: rtl/bfl_array.sv
`timescale 1ns/1ps
module bfl_array
  import bfl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (rd_en_i) q <= array_word(DW'(rd_addr_i));
  end

  assign rdata_o = q;
endmodule

// File: rtl/bfl_out_stage.sv
`timescale 1ns/1ps
module bfl_out_stage
  import bfl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          async_i,
  input  logic          early_i,
  input  logic          fall_i,
  input  logic          fire_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic          rdy_o
);
  logic          vld_q, vn_q;
  logic [DW-1:0] dn_q, data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else vld_q <= fire_i;
  end

  // half-cycle delayed copy for falling-edge launch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_q <= '0;
      vn_q <= 1'b0;
    end else begin
      dn_q <= rdata_i;
      vn_q <= vld_q;
    end
  end

  always_comb begin
    data = (!async_i && fall_i) ? dn_q : rdata_i;
    if (async_i)      rdy_o = vld_q;
    else if (early_i) rdy_o = fire_i;
    else              rdy_o = fall_i ? vn_q : vld_q;
    dout_en_o = !ce_ni && !oe_ni && we_ni;
    dout_o    = dout_en_o ? data : '0;
  end
endmodule

// File: rtl/bflash_rd_if.sv
`timescale 1ns/1ps
module bflash_rd_if
  import bfl_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ASYNC_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          lat_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          adv_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   din_i,
  output logic [31:0]   dout_o,
  output logic          dout_en_o,
  output logic          rdy_o
);
  cfg_t          cfg;
  logic          cfg_wr, fire;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rdata;

  assign cfg_wr = !ce_ni && !we_ni && (din_i[31:16] == CFG_CMD);

  bfl_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .wdata_i (din_i[15:0]),
    .cfg_o   (cfg)
  );

  bfl_burst_seq #(.AW(AW), .ASYNC_LAT(ASYNC_LAT)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .async_i   (cfg.async_m),
    .lat_i     (cfg.lat),
    .sp2_i     (cfg.sp2),
    .seq_i     (cfg.seq_o),
    .nowrap_i  (cfg.nowrap),
    .len_i     (cfg.len),
    .ce_ni     (ce_ni),
    .lat_ni    (lat_ni),
    .we_ni     (we_ni),
    .adv_ni    (adv_ni),
    .addr_i    (addr_i),
    .fire_o    (fire),
    .rd_addr_o (rd_addr)
  );

  bfl_array #(.AW(AW)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (fire),
    .rd_addr_i (rd_addr),
    .rdata_o   (rdata)
  );

  bfl_out_stage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .async_i   (cfg.async_m),
    .early_i   (cfg.early),
    .fall_i    (cfg.fall),
    .fire_i    (fire),
    .rdata_i   (rdata),
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .rdy_o     (rdy_o)
  );
endmodule

// File: tb/bflash_rd_if_bench.sv
`timescale 1ns/1ps
module bflash_rd_if_bench;
  localparam int AW = 8;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          rst_ni, ce_ni, lat_ni, oe_ni, we_ni, adv_ni;
  logic [AW-1:0] addr_i;
  logic [31:0]   din_i, dout_o;
  logic          dout_en_o, rdy_o;

  bflash_rd_if #(.AW(AW)) u_bflash_rd_if (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .lat_ni(lat_ni), .oe_ni(oe_ni),
    .we_ni(we_ni), .adv_ni(adv_ni), .addr_i(addr_i), .din_i(din_i),
    .dout_o(dout_o), .dout_en_o(dout_en_o), .rdy_o(rdy_o)
  );

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit mon_en = 0, early_m = 0, pend = 0;
  int          qc[$];
  logic [31:0] qd[$];
  string       qt[$];

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] av;
    av = 32'(a & 255);
    return (av * 32'h0001_0001) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_addr(input int base, input int pos, input int nlen,
                                  input bit wrap, input bit seqo);
    int m;
    if (nlen == 0) return (base + pos) & 255;
    m = nlen - 1;
    if (!seqo) return (base & ~m) | ((base ^ pos) & m);
    if (wrap)  return (base & ~m) | ((base + pos) & m);
    return (base + pos) & 255;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic pop_cmp();
    int c; logic [31:0] d; string t;
    if (qc.size() == 0) begin
      chk(1'b0, "R12", dout_o, 32'h0, "unexpected ready");
    end else begin
      c = qc.pop_front(); d = qd.pop_front(); t = qt.pop_front();
      chk(dout_o === d, t, dout_o, d, "beat data");
      chk(cyc == c, t, 32'(cyc), 32'(c), "beat cycle");
    end
  endtask

  // monitor: scoreboard pop on each ready
  always @(posedge clk_i) begin
    #3;
    if (mon_en) begin
      if (pend) begin
        pend = 0;
        pop_cmp();
      end
      if (rdy_o) begin
        if (early_m) pend = 1;
        else pop_cmp();
      end
    end
  end

  task automatic wr_cfg(input logic [15:0] cmd, input logic [15:0] v);
    @(negedge clk_i); ce_ni = 0; we_ni = 0; lat_ni = 1; din_i = {cmd, v};
    @(posedge clk_i);
    @(negedge clk_i); we_ni = 1; ce_ni = 1; din_i = '0;
  endtask

  // driver: latch, push expected beats, drive advance on fire edges
  task automatic run_burst(input int base, input int lat, input int sp, input int nb,
                           input int hold, input int nlen, input bit wrap, input bit seqo,
                           input bit oe_on, input bit fall_chk, input string tag);
    int c0, pos, jl, k;
    @(negedge clk_i);
    ce_ni = 0; lat_ni = 0; oe_ni = !oe_on; adv_ni = 1; addr_i = base[AW-1:0];
    @(posedge clk_i);
    #1 c0 = cyc;
    pos = 0;
    for (int b = 0; b < nb; b++) begin
      if (b > 0 && !hold[b]) pos++;
      qc.push_back(c0 + lat - 1 + b * sp);
      qd.push_back(oe_on ? exp_word(exp_addr(base, pos, nlen, wrap, seqo)) : 32'h0);
      qt.push_back(tag);
    end
    jl = lat - 1 + (nb - 1) * sp;
    @(negedge clk_i); lat_ni = 1;
    for (int j = 1; j <= jl; j++) begin
      if (j > 1) @(negedge clk_i);
      k = j - (lat - 1);
      adv_ni = 1;
      if (k > 0 && (k % sp) == 0 && (k / sp) < nb) adv_ni = hold[k / sp];
      @(posedge clk_i);
      if (fall_chk && j == lat - 1) begin
        #1 chk(rdy_o == 1'b0, "R9", 32'(rdy_o), 32'h0, "ready before falling edge");
      end
    end
    @(negedge clk_i); #1.5;
    ce_ni = 1; oe_ni = 1; adv_ni = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_ni = 0; ce_ni = 1; lat_ni = 1; oe_ni = 1; we_ni = 1; adv_ni = 1;
    addr_i = '0; din_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(rdy_o == 1'b0, "R1", 32'(rdy_o), 32'h0, "ready in reset");
    chk(dout_en_o == 1'b0, "R11", 32'(dout_en_o), 32'h0, "drive while deselected");
    rst_ni = 1;
    @(negedge clk_i); ce_ni = 0; oe_ni = 0;
    #1 chk(dout_o == 32'h0, "R1", dout_o, 32'h0, "idle word after reset");
    chk(dout_en_o == 1'b1, "R11", 32'(dout_en_o), 32'h1, "drive when enabled");
    @(negedge clk_i); ce_ni = 1; oe_ni = 1;
    mon_en = 1;

    // R1 asynchronous default
    run_burst(8'h33, 3, 1, 1, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R1");
    // R2 wrong command, reserved latency codes
    wr_cfg(16'h0000, 16'h1881);
    run_burst(8'h34, 3, 1, 1, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    wr_cfg(16'h6000, 16'h3881);
    run_burst(8'h35, 3, 1, 1, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    wr_cfg(16'h6000, 16'h0081);
    run_burst(8'h36, 3, 1, 1, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    // R3 R6 sync, latency 6, wrap sequential 4
    wr_cfg(16'h6000, 16'h1881);
    run_burst(8'h0E, 6, 1, 4, 0, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    // R8 hold on beats 2 and 3
    run_burst(8'h21, 6, 1, 6, 12, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
    // R6 no wrap
    wr_cfg(16'h6000, 16'h1889);
    run_burst(8'h0E, 6, 1, 4, 0, 4, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    // R7 interleaved 8, latency 4, spacing 2
    wr_cfg(16'h6000, 16'h0A02);
    run_burst(8'h15, 4, 2, 8, 0, 8, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    // R4 spacing 2 sequential
    wr_cfg(16'h6000, 16'h1A81);
    run_burst(8'h40, 6, 2, 4, 0, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    // R5 continuous, latency 8, then deselect (R12)
    wr_cfg(16'h6000, 16'h2887);
    run_burst(8'hFC, 8, 1, 10, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    repeat (12) @(posedge clk_i);
    #3 chk(rdy_o == 1'b0, "R12", 32'(rdy_o), 32'h0, "ready after deselect");
    chk(qc.size() == 0, "R12", 32'(qc.size()), 32'h0, "beats pending after deselect");
    // R9 falling edge launch
    wr_cfg(16'h6000, 16'h18C1);
    run_burst(8'h50, 6, 1, 4, 0, 4, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
    // R10 early ready, latency 5, spacing 2
    wr_cfg(16'h6000, 16'h1381);
    early_m = 1;
    run_burst(8'h62, 5, 2, 4, 0, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
    repeat (3) @(posedge clk_i);
    early_m = 0;
    // R11 output enable held off
    wr_cfg(16'h6000, 16'h1881);
    run_burst(8'h70, 6, 1, 4, 0, 4, 1'b1, 1'b1, 1'b0, 1'b0, "R11");

    repeat (5) @(posedge clk_i);
    chk(qc.size() == 0, "R5", 32'(qc.size()), 32'h0, "beats never delivered");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule